// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block watches over running software with two timeout counters. The counters advance together on a shared tick, and a prescaler makes that tick by dividing the system clock. Each counter is compared against its own programmable limit. The first stage raises a sticky interrupt request that is meant to be routed to the platform interrupt controller as an external interrupt, so that software can try to recover or shut down cleanly. The second stage, normally given the longer limit, raises a sticky hard-panic pin that system logic can use to reset or recover the system.

Software keeps the block quiet by patting it regularly. A pat is a write of a fixed key to a dedicated register. It returns both counters and the prescaler to zero and removes a pending interrupt. The pat period must stay below the first-stage timeout; if it does, neither output ever rises. The limits can be changed only while the block is disabled. Clearing the enable bit stops the counters and drops both outputs.

Top module: `dual_stage_watchdog`

## Requirements
- R1: After reset, `irq_soft` and `panic_hard` are low, and every readable register reads zero: control, both limits and status.
- R2: While enable (control bit 0, address 0) is low, both counters and the prescaler are held at zero. One clock after enable goes low, both outputs are low and they stay low.
- R3: A counter advances once every PRESCALE clocks. `irq_soft` rises exactly SOFT_LIMIT×PRESCALE clock edges after the edge that enabled the block or accepted a pat.
- R4: `panic_hard` rises exactly HARD_LIMIT×PRESCALE clock edges after the edge that enabled the block or accepted a pat.
- R5: A write of 0x5AFEC0DE to the pat register (address 3) clears both counters and the prescaler, and it lowers `irq_soft`. A write of any other value to that address has no effect.
- R6: `irq_soft` stays high until a write with bit 0 set to the status register (address 4), or until a pat. After such a write-1-to-clear, the first counter stays at its limit, so the interrupt does not return before the next pat.
- R7: While the block is enabled, `panic_hard` stays high once set. Neither a pat nor a write to status bit 1 lowers it; only reset or disabling does.
- R8: Writes to the soft limit (address 1) and the hard limit (address 2) are ignored while the block is enabled.
- R9: A limit of zero turns its stage off: that output never rises.
- R10: Reads return data one clock after `bus_re`. Status reads bit 0 = soft flag and bit 1 = hard flag. Unused addresses (5 to 7) read zero.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, registered |
| irq_soft | output | 1 | Sticky first-stage interrupt request |
| panic_hard | output | 1 | Sticky second-stage hard-panic pin |

## Verification
Timeouts are measured to the exact clock edge from two starting points: an enable and a pat. This separates a prescaler or compare that is off by one from a correct one. Three patting patterns are used. Regular pats inside the window show that nothing fires. A wrong-key write in the middle of a window must leave the original deadline unchanged. A write-1-to-clear without a pat shows the difference between clearing the flag and restarting the count. Limit writes while enabled, a zero limit and the disable path show which changes reach the outputs and which are held off.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef logic [2:0] addr_t;
  localparam addr_t ADR_CTRL   = 3'd0;
  localparam addr_t ADR_LIM_S  = 3'd1;
  localparam addr_t ADR_LIM_H  = 3'd2;
  localparam addr_t ADR_PAT    = 3'd3;
  localparam addr_t ADR_STATUS = 3'd4;
  localparam logic [31:0] PAT_KEY = 32'h5AFE_C0DE;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int PRESCALE = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

  logic [PW-1:0] pcnt;

  assign tick = run && !restart && (pcnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run || restart || tick) pcnt <= '0;
    else                                pcnt <= pcnt + 1'b1;
  end
endmodule

// File: rtl/wdt_stage.sv
module wdt_stage #(
  parameter int W          = 32,
  parameter bit CLR_ON_PAT = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         tick,
  input  logic         pat,
  input  logic         w1c,
  input  logic [W-1:0] limit,
  output logic [W-1:0] cnt,
  output logic         flag
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic step, hit, soft_clr;

  assign step = en && !pat && tick && (cnt != limit);
  assign hit  = step && ((cnt + ONE) == limit);

  always_ff @(posedge clk) begin
    if (rst || !en || pat) cnt <= '0;
    else if (step)         cnt <= cnt + ONE;
  end

  generate
    if (CLR_ON_PAT) begin : g_soft
      assign soft_clr = pat || w1c;
    end else begin : g_hard
      assign soft_clr = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || !en)    flag <= 1'b0;
    else if (hit)      flag <= 1'b1;
    else if (soft_clr) flag <= 1'b0;
  end
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic         re,
  input  addr_t        addr,
  input  logic [W-1:0] wdata,
  input  logic         flag_s,
  input  logic         flag_h,
  output logic [W-1:0] rdata,
  output logic         en,
  output logic [W-1:0] lim_s,
  output logic [W-1:0] lim_h,
  output logic         pat,
  output logic         w1c_s
);
  localparam logic [W-1:0] KEY = PAT_KEY[W-1:0];

  assign pat   = we && en && (addr == ADR_PAT) && (wdata == KEY);
  assign w1c_s = we && (addr == ADR_STATUS) && wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      en    <= 1'b0;
      lim_s <= '0;
      lim_h <= '0;
    end else if (we) begin
      if (addr == ADR_CTRL)             en    <= wdata[0];
      if (addr == ADR_LIM_S && !en)     lim_s <= wdata;
      if (addr == ADR_LIM_H && !en)     lim_h <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (re) begin
      case (addr)
        ADR_CTRL:   rdata <= W'(en);
        ADR_LIM_S:  rdata <= lim_s;
        ADR_LIM_H:  rdata <= lim_h;
        ADR_STATUS: rdata <= W'({flag_h, flag_s});
        default:    rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/dual_stage_watchdog.sv
module dual_stage_watchdog
  import wdt_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int PRESCALE = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [2:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_soft,
  output logic              panic_hard
);
  logic              en, pat, w1c_s, tick;
  logic [DATA_W-1:0] lim_s, lim_h, cnt_s, cnt_h;

  wdt_regs #(.W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .we(bus_we), .re(bus_re), .addr(bus_addr),
    .wdata(bus_wdata), .flag_s(irq_soft), .flag_h(panic_hard),
    .rdata(bus_rdata), .en(en), .lim_s(lim_s), .lim_h(lim_h),
    .pat(pat), .w1c_s(w1c_s)
  );

  wdt_prescaler #(.PRESCALE(PRESCALE)) u_pre (
    .clk(clk), .rst(rst), .run(en), .restart(pat), .tick(tick)
  );

  wdt_stage #(.W(DATA_W), .CLR_ON_PAT(1'b1)) u_soft (
    .clk(clk), .rst(rst), .en(en), .tick(tick), .pat(pat), .w1c(w1c_s),
    .limit(lim_s), .cnt(cnt_s), .flag(irq_soft)
  );

  wdt_stage #(.W(DATA_W), .CLR_ON_PAT(1'b0)) u_hard (
    .clk(clk), .rst(rst), .en(en), .tick(tick), .pat(pat), .w1c(1'b0),
    .limit(lim_h), .cnt(cnt_h), .flag(panic_hard)
  );
endmodule

module dual_stage_watchdog_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         en,
  input logic         pat,
  input logic         tick,
  input logic         bus_we,
  input logic [2:0]   bus_addr,
  input logic [W-1:0] lim_s,
  input logic [W-1:0] lim_h,
  input logic [W-1:0] cnt_s,
  input logic [W-1:0] cnt_h,
  input logic         irq_soft,
  input logic         panic_hard
);
  // R2
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!irq_soft && !panic_hard));
  // R7
  panic_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (panic_hard && en) |=> panic_hard);
  // R3
  soft_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_soft) |-> $past(tick));
  // R4
  hard_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(panic_hard) |-> $past(tick));
  // R8
  limit_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (en && bus_we && (bus_addr == 3'd1 || bus_addr == 3'd2)) |=>
      ($stable(lim_s) && $stable(lim_h)));
  // R9
  zero_limit_chk: assert property (@(posedge clk) disable iff (rst)
    ((lim_s == '0) |-> !irq_soft) and ((lim_h == '0) |-> !panic_hard));
  // R6
  saturate_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_s <= lim_s) && (cnt_h <= lim_h));
  // R5
  pat_clears_chk: assert property (@(posedge clk) disable iff (rst)
    pat |=> (cnt_s == '0 && cnt_h == '0 && !irq_soft));
endmodule

bind dual_stage_watchdog dual_stage_watchdog_chk #(.W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .pat(pat), .tick(tick), .bus_we(bus_we),
  .bus_addr(bus_addr), .lim_s(lim_s), .lim_h(lim_h), .cnt_s(cnt_s),
  .cnt_h(cnt_h), .irq_soft(irq_soft), .panic_hard(panic_hard)
);

// File: tb/dual_stage_watchdog_test.sv
`timescale 1ns/1ps
module dual_stage_watchdog_test;
  localparam int P  = 4;
  localparam int LS = 5;
  localparam int LH = 9;
  localparam int TS = LS * P;
  localparam int TH = LH * P;
  localparam logic [31:0] KEY = 32'h5AFE_C0DE;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        we = 1'b0, re = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, panic;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dual_stage_watchdog #(.DATA_W(32), .PRESCALE(P)) uut (
    .clk(clk), .rst(rst), .bus_we(we), .bus_re(re), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq_soft(irq), .panic_hard(panic)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); re = 1'b1; addr = a;
    @(posedge clk);
    @(negedge clk); re = 1'b0; d = rdata;
  endtask

  task automatic wait_edges(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 panic", {31'b0, panic}, 0);
    rd(3'd0, v); check("R1 ctrl", v, 0);
    rd(3'd1, v); check("R1 lim_s", v, 0);
    rd(3'd4, v); check("R1 status", v, 0);
  endtask

  task automatic t_timeouts();
    logic [31:0] v;
    wr(3'd1, LS); wr(3'd2, LH);
    rd(3'd1, v); check("R10 lim_s readback", v, LS);
    wr(3'd0, 1);
    wait_edges(TS - 1); check("R3 irq before", {31'b0, irq}, 0);
    wait_edges(1);      check("R3 irq at limit", {31'b0, irq}, 1);
    wait_edges(TH - TS - 1); check("R4 panic before", {31'b0, panic}, 0);
    wait_edges(1);      check("R4 panic at limit", {31'b0, panic}, 1);
    rd(3'd4, v); check("R10 status both", v, 3);
    wr(3'd3, KEY);
    check("R5 pat clears irq", {31'b0, irq}, 0);
    check("R7 pat keeps panic", {31'b0, panic}, 1);
    wr(3'd4, 2);
    check("R7 w1c keeps panic", {31'b0, panic}, 1);
    wr(3'd0, 0);
    wait_edges(1);
    check("R2 disable irq", {31'b0, irq}, 0);
    check("R2 disable panic", {31'b0, panic}, 0);
    wait_edges(TH + 4);
    check("R2 held off", {30'b0, panic, irq}, 0);
  endtask

  task automatic t_w1c();
    wr(3'd0, 1);
    wait_edges(TS); check("R6 irq set", {31'b0, irq}, 1);
    wr(3'd4, 1);
    check("R6 w1c clears", {31'b0, irq}, 0);
    wait_edges(8); check("R6 no refire", {31'b0, irq}, 0);
    wr(3'd3, KEY);
    wait_edges(TS - 1); check("R6 after pat before", {31'b0, irq}, 0);
    wait_edges(1);      check("R6 after pat fires", {31'b0, irq}, 1);
    wr(3'd0, 0); wait_edges(1);
  endtask

  task automatic t_patting();
    wr(3'd0, 1);
    for (int i = 0; i < 5; i++) begin
      wait_edges(TS - 6);
      wr(3'd3, KEY);
      check("R5 regular pats irq", {31'b0, irq}, 0);
    end
    check("R5 regular pats panic", {31'b0, panic}, 0);
    wait_edges(TS - 6);
    wr(3'd3, 32'h1234_5678);
    wait_edges(3); check("R5 bad key before", {31'b0, irq}, 0);
    wait_edges(1); check("R5 bad key ignored", {31'b0, irq}, 1);
    wr(3'd0, 0); wait_edges(1);
  endtask

  task automatic t_lock_zero();
    logic [31:0] v;
    wr(3'd0, 1);
    wr(3'd1, 2); wr(3'd2, 3);
    rd(3'd1, v); check("R8 lim_s locked", v, LS);
    rd(3'd2, v); check("R8 lim_h locked", v, LH);
    wr(3'd0, 0);
    wr(3'd1, 0); wr(3'd2, 3);
    wr(3'd0, 1);
    wait_edges(3 * P - 1); check("R9 hard before", {31'b0, panic}, 0);
    wait_edges(1);         check("R9 hard fires", {31'b0, panic}, 1);
    wait_edges(TS * 2);    check("R9 soft off", {31'b0, irq}, 0);
    rd(3'd7, v); check("R10 unused addr", v, 0);
    wr(3'd0, 0); wait_edges(1);
  endtask

  initial begin
    wait_edges(3);
    rst = 1'b0;
    wait_edges(1);
    t_reset();
    t_timeouts();
    t_w1c();
    t_patting();
    t_lock_zero();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule